// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns bytes from a register bus into an asynchronous serial stream on one output line. Software writes a byte into a bus-visible holding register and then clears a ready flag to mark the byte as pending. The shifter is a separate register that software cannot reach. When the shifter is free, it takes the pending byte on a baud tick and sets the ready flag again. Software can then load the next byte while the current one is still going out.

Frames are a low start bit, eight data bits sent least significant bit first, and a high stop bit. Each bit lasts one baud-tick period, and the line rests high between frames. If the next byte is pending by the time the stop bit ends, its start bit follows at once with no idle time. A transmit-end output reports that the line has gone idle with nothing pending. A standby input parks the whole path: the holding register goes to all ones, the flag reads 1, any frame in progress is dropped and the line stays high.

Top module: `dbtx_top`

## Requirements
- R1: After reset, tx_out is 1, rd_data is 0xFF, flag_empty is 1 and tx_end is 1.
- R2: Outside standby, a write strobe loads the holding register at the clock edge, and rd_data shows the holding register from the next cycle. This applies while a frame is shifting too, and such a write leaves the bits of that frame unchanged.
- R3: A bus flag write with value 0 clears flag_empty. While flag_empty is 1 no byte is copied to the shifter, and an idle line stays at 1.
- R4: On a baud tick where the shifter is free and flag_empty is 0, the held byte is copied. From that edge on, the line carries a start bit of 0, then data bits 0 to 7, then a stop bit of 1, and each bit changes only on a baud tick.
- R5: flag_empty returns to 1 at the same clock edge that copies the byte into the shifter.
- R6: If flag_empty is 0 on the tick that ends a stop bit, the next start bit begins on that same tick, so the two frames have no idle period between them.
- R7: A bus flag write with value 1 leaves flag_empty unchanged.
- R8: While standby is 1, the holding register reads 0xFF, bus writes are ignored, flag_empty is 1, the line is 1 and tx_end is 1. A frame in progress is abandoned and does not resume.
- R9: tx_end rises when a stop bit completes with flag_empty at 1, and falls at the edge that copies a new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| standby | input | 1 | Standby request, active high |
| baud_tick | input | 1 | One-cycle pulse per serial bit period |
| wr_en | input | 1 | Holding register write strobe |
| wr_data | input | 8 | Holding register write data |
| rd_data | output | 8 | Holding register read data |
| flag_wr_en | input | 1 | Ready flag write strobe |
| flag_wr_val | input | 1 | Value written to the ready flag (only 0 acts) |
| flag_empty | output | 1 | Ready flag: 1 when the holding register has been consumed |
| tx_out | output | 1 | Serial output line |
| tx_end | output | 1 | Transmit-end status |

## Verification
A single directed byte whose value is not a palindrome shows whether the bits go out least significant bit first and one tick apart. A rewrite of the holding register during that frame tells a leaky shifter apart from one that holds its own copy. A burst of random bytes, each loaded as soon as the flag reads 1, is decoded from the line. It exposes lost or duplicated handoffs, and any idle tick between frames marks a broken gap-free path. Flag writes of 1 mixed into the burst, the idle ticks with the flag at 1, and a standby pulse in the middle of a frame separate a correct flag and parking logic from one that sends stale or abandoned data.

// File: rtl/dbtx_pkg.sv
package dbtx_pkg;

  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_BUSY = 1'b1
  } tx_phase_e;

  // start bit + data bits + stop bit
  function automatic int frame_len(input int data_w);
    return data_w + 2;
  endfunction

endpackage

// File: rtl/dbtx_holdreg.sv
module dbtx_holdreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              flag_wr_en_i,
  input  logic              flag_wr_val_i,
  input  logic              load_i,
  output logic [DATA_W-1:0] hold_o,
  output logic              empty_o
);

  localparam logic [DATA_W-1:0] PARK_VAL = '1;

  logic clear_evt;
  assign clear_evt = flag_wr_en_i && !flag_wr_val_i && !standby_i;

  function automatic logic next_flag(input logic cur, input logic stby,
                                     input logic ld, input logic clr);
    if (stby)     return 1'b1;
    else if (ld)  return 1'b1;
    else if (clr) return 1'b0;
    else          return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_o  <= PARK_VAL;
      empty_o <= 1'b1;
    end else begin
      empty_o <= next_flag(empty_o, standby_i, load_i, clear_evt);
      if (standby_i)    hold_o <= PARK_VAL;
      else if (wr_en_i) hold_o <= wr_data_i;
    end
  end

  AST_FLAG_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> empty_o); // R5
  AST_SET_ONE_NOEFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr_en_i && flag_wr_val_i && !empty_o && !load_i && !standby_i) |=> !empty_o); // R7
  AST_STANDBY_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    standby_i |=> (hold_o == PARK_VAL) && empty_o); // R8
  AST_HOLD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !standby_i) |=> hold_o == $past(wr_data_i)); // R2

endmodule

// File: rtl/dbtx_shifter.sv
module dbtx_shifter
  import dbtx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby_i,
  input  logic              tick_i,
  input  logic              empty_i,
  input  logic [DATA_W-1:0] hold_i,
  output logic              load_o,
  output logic              tx_o,
  output logic              tx_end_o
);

  localparam int FRAME_LEN = frame_len(DATA_W);
  localparam int CNT_W     = $clog2(FRAME_LEN);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_LEN - 1);

  function automatic logic [FRAME_LEN-1:0] build_frame(input logic [DATA_W-1:0] d);
    return {1'b1, d, 1'b0};
  endfunction

  tx_phase_e            phase_q;
  logic [FRAME_LEN-1:0] sreg_q;
  logic [CNT_W-1:0]     cnt_q;
  logic                 end_q;
  logic                 at_last;
  logic                 frame_done;

  assign at_last    = (phase_q == TX_BUSY) && (cnt_q == LAST_IDX);
  assign frame_done = tick_i && at_last && !standby_i;
  assign load_o     = tick_i && !standby_i && !empty_i &&
                      ((phase_q == TX_IDLE) || at_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= TX_IDLE;
      sreg_q  <= '1;
      cnt_q   <= '0;
      end_q   <= 1'b1;
    end else if (standby_i) begin
      phase_q <= TX_IDLE;
      sreg_q  <= '1;
      cnt_q   <= '0;
      end_q   <= 1'b1;
    end else if (load_o) begin
      phase_q <= TX_BUSY;
      sreg_q  <= build_frame(hold_i);
      cnt_q   <= '0;
      end_q   <= 1'b0;
    end else if (frame_done) begin
      phase_q <= TX_IDLE;
      sreg_q  <= '1;
      cnt_q   <= '0;
      end_q   <= 1'b1;
    end else if (tick_i && phase_q == TX_BUSY) begin
      sreg_q  <= {1'b1, sreg_q[FRAME_LEN-1:1]};
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign tx_o     = (phase_q == TX_BUSY) ? sreg_q[0] : 1'b1;
  assign tx_end_o = end_q;

  AST_LOAD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> !empty_i); // R3
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !tx_o); // R4
  AST_GAPLESS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !empty_i) |-> load_o); // R6
  AST_END_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && empty_i) |=> tx_end_o); // R9
  AST_END_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !tx_end_o); // R9
  AST_END_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    tx_end_o |-> tx_o); // R9

endmodule

// File: rtl/dbtx_top.sv
module dbtx_top #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              flag_wr_en,
  input  logic              flag_wr_val,
  output logic              flag_empty,
  output logic              tx_out,
  output logic              tx_end
);

  logic              load_evt;
  logic [DATA_W-1:0] hold_q;
  logic              empty_q;

  dbtx_holdreg #(.DATA_W(DATA_W)) u_hold (
    .clk          (clk),
    .rst_n        (rst_n),
    .standby_i    (standby),
    .wr_en_i      (wr_en),
    .wr_data_i    (wr_data),
    .flag_wr_en_i (flag_wr_en),
    .flag_wr_val_i(flag_wr_val),
    .load_i       (load_evt),
    .hold_o       (hold_q),
    .empty_o      (empty_q)
  );

  dbtx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .standby_i(standby),
    .tick_i   (baud_tick),
    .empty_i  (empty_q),
    .hold_i   (hold_q),
    .load_o   (load_evt),
    .tx_o     (tx_out),
    .tx_end_o (tx_end)
  );

  assign rd_data    = hold_q;
  assign flag_empty = empty_q;

  AST_STANDBY_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> tx_out && tx_end); // R8
  AST_NO_LOAD_IN_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !load_evt); // R8

endmodule

// File: tb/sim_dbtx_top.sv
module sim_dbtx_top;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 8;
  localparam int NB         = 20;

  logic clk = 1'b0, rst_n = 1'b0, standby = 1'b0, baud_tick = 1'b0;
  logic wr_en = 1'b0, flag_wr_en = 1'b0, flag_wr_val = 1'b1;
  logic [7:0] wr_data = 8'h00;
  wire  [7:0] rd_data;
  wire        flag_empty, tx_out, tx_end;

  int checks = 0, fails = 0;
  bit finished = 0;

  dbtx_top u0 (
    .clk(clk), .rst_n(rst_n), .standby(standby), .baud_tick(baud_tick),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .flag_wr_en(flag_wr_en), .flag_wr_val(flag_wr_val), .flag_empty(flag_empty),
    .tx_out(tx_out), .tx_end(tx_end)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    int div;
    div = 0;
    forever begin
      @(negedge clk);
      baud_tick = (div == TICK_DIV - 1);
      div = (div == TICK_DIV - 1) ? 0 : div + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // bench-side frame rules
  function automatic bit lsb_bit(input logic [7:0] b, input int k);
    return b[k];
  endfunction

  // line monitor / decoder
  bit mon_en = 0;
  int st = 0, idle_run = 0, rx_cnt = 0, frame_errs = 0;
  logic [7:0] rx_sh;
  logic [7:0] rx_q [NB];
  int gap_q [NB];

  initial begin
    bit tk;
    forever begin
      @(posedge clk);
      tk = baud_tick;
      #1;
      if (!mon_en) begin
        st = 0; idle_run = 0;
      end else if (tk) begin
        if (st == 0) begin
          if (tx_out == 1'b0) begin
            if (rx_cnt < NB) gap_q[rx_cnt] = idle_run;
            st = 1;
          end else idle_run++;
        end else if (st <= 8) begin
          rx_sh[st-1] = tx_out;
          st++;
        end else begin
          if (tx_out !== 1'b1) frame_errs++;
          if (rx_cnt < NB) rx_q[rx_cnt] = rx_sh;
          rx_cnt++;
          idle_run = 0;
          st = 0;
        end
      end
    end
  end

  task automatic wait_tick();
    do @(posedge clk); while (!baud_tick);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp_q [NB];
    logic [7:0] b;
    int sd;
    sd = $urandom(32'd20240611);

    // R1 reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_out == 1'b1, "R1 line", tx_out, 1);
    check(rd_data == 8'hFF, "R1 holding", rd_data, 8'hFF);
    check(flag_empty == 1'b1, "R1 flag", flag_empty, 1);
    check(tx_end == 1'b1, "R1 tx_end", tx_end, 1);

    // directed byte 0x35, with a write of 1 to the flag after clearing
    wait_tick();
    wr_en = 1'b1; wr_data = 8'h35; flag_wr_en = 1'b1; flag_wr_val = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; flag_wr_val = 1'b1;
    check(rd_data == 8'h35, "R2 readback", rd_data, 8'h35);
    check(flag_empty == 1'b0, "R3 clear", flag_empty, 0);
    @(negedge clk);
    flag_wr_en = 1'b0;
    check(flag_empty == 1'b0, "R7 write one", flag_empty, 0);
    wait_tick();
    check(flag_empty == 1'b1, "R5 flag on load", flag_empty, 1);
    check(tx_end == 1'b0, "R9 end falls", tx_end, 0);
    check(tx_out == 1'b0, "R4 start bit", tx_out, 0);
    wr_en = 1'b1; wr_data = 8'hC3;
    @(negedge clk);
    wr_en = 1'b0;
    check(rd_data == 8'hC3, "R2 write while shifting", rd_data, 8'hC3);
    for (int k = 0; k < 8; k++) begin
      wait_tick();
      check(tx_out == lsb_bit(8'h35, k), "R4 data bit", tx_out, lsb_bit(8'h35, k));
    end
    wait_tick();
    check(tx_out == 1'b1, "R4 stop bit", tx_out, 1);
    wait_tick();
    check(tx_end == 1'b1, "R9 end rises", tx_end, 1);
    for (int k = 0; k < 4; k++) begin
      check(tx_out == 1'b1, "R3 no copy while flag set", tx_out, 1);
      wait_tick();
    end

    // random burst, each byte loaded as soon as the flag reads 1
    mon_en = 1;
    for (int i = 0; i < NB; i++) begin
      while (!flag_empty) @(negedge clk);
      b = 8'($urandom);
      wr_en = 1'b1; wr_data = b;
      if ($urandom % 2) begin
        flag_wr_en = 1'b1; flag_wr_val = 1'b1;
        @(negedge clk);
        b = 8'($urandom);
        wr_data = b;
      end
      flag_wr_en = 1'b1; flag_wr_val = 1'b0;
      exp_q[i] = b;
      @(negedge clk);
      wr_en = 1'b0; flag_wr_en = 1'b0; flag_wr_val = 1'b1;
    end
    while (!tx_end) @(negedge clk);
    wait_tick(); wait_tick();
    mon_en = 0;
    check(rx_cnt == NB, "R4 frame count", rx_cnt, NB);
    check(frame_errs == 0, "R4 stop bits", frame_errs, 0);
    for (int i = 0; i < NB; i++)
      check(rx_q[i] == exp_q[i], "R4 burst byte", rx_q[i], exp_q[i]);
    for (int i = 1; i < NB; i++)
      check(gap_q[i] == 0, "R6 no idle gap", gap_q[i], 0);

    // standby in the middle of a frame
    wait_tick();
    wr_en = 1'b1; wr_data = 8'h0F; flag_wr_en = 1'b1; flag_wr_val = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; flag_wr_en = 1'b0; flag_wr_val = 1'b1;
    wait_tick(); wait_tick(); wait_tick();
    standby = 1'b1;
    wr_en = 1'b1; wr_data = 8'h12; flag_wr_en = 1'b1; flag_wr_val = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; flag_wr_en = 1'b0; flag_wr_val = 1'b1;
    check(tx_out == 1'b1, "R8 line", tx_out, 1);
    check(rd_data == 8'hFF, "R8 holding", rd_data, 8'hFF);
    check(flag_empty == 1'b1, "R8 flag", flag_empty, 1);
    check(tx_end == 1'b1, "R8 tx_end", tx_end, 1);
    @(negedge clk);
    standby = 1'b0;
    @(negedge clk);
    check(rd_data == 8'hFF, "R8 write ignored", rd_data, 8'hFF);
    begin
      int low;
      low = 0;
      for (int k = 0; k < 12; k++) begin
        wait_tick();
        if (tx_out !== 1'b1) low++;
      end
      check(low == 0, "R8 frame abandoned", low, 0);
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule